// File: doc/BRIEF.md
# Register-List Block Transfer Sequencer

This block moves a set of general registers to or from memory, one 32-bit word per cycle. An 8-bit register mask selects the registers that take part. A 2-bit operation code picks one of four kinds of transfer:

- an ascending load from a base address;
- an ascending store to a base address;
- a stack push;
- a stack pop.

Push can also save the link register, and pop can also reload the program counter. The block holds no data of its own. It reads and writes the eight low registers through a register-file port, and it drives a valid/ready memory port. When the transfer ends, it reports the updated base or stack pointer so the caller can write it back.

A transfer starts with a one-cycle `start_i` while the block is idle. The sequencer visits the selected registers in the order the operation requires. It stalls for as long as memory withholds ready. After the last access it returns a one-cycle completion pulse, together with the write-back value, the write-back enable and, if the program counter was reloaded, the branch target.

Top module: `blk_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `mem_valid_o`, `done_o`, `wb_en_o`, `pc_load_o` and `rf_we_o` are all 0.
- R2: Mask bit i selects register i (0..7). Ascending load (op 2'b00) and ascending store (op 2'b01) visit the selected registers from bit 0 upward. The first access is at the base address and each later access is 4 higher.
- R3: A load writes the memory read data into the visited register in the cycle the access completes. A store (and a push) writes that register's value to memory.
- R4: Push (op 2'b10) starts at base minus 4 and visits the selected registers from bit 7 downward, stepping the address down by 4.
- R5: A push with `extra_i`=1 stores `lr_i` first, at base minus 4, before any listed register.
- R6: Pop (op 2'b11) visits the selected registers upward from the base. With `extra_i`=1 it then reads one more word. That word, with bit 0 cleared, is reported on `pc_value_o`, and `pc_load_o` is raised with `done_o`.
- R7: After a push the reported stack pointer is the lowest address written. After a pop it is one word past the last address read.
- R8: An ascending load reports `wb_en_o`=0 when `base_idx_i` is set in the mask and 1 otherwise. An ascending store, a push and a pop always report `wb_en_o`=1.
- R9: `done_o` is high for exactly one cycle, one cycle after the last access completes. In that cycle `busy_o` is 0.
- R10: An empty mask with no extra word makes no memory access and still completes with the write-back value: the base itself, unchanged, for every operation.
- R11: While `mem_ready_i` is 0, the pending access holds its valid, address and direction. At most one access completes per cycle.
- R12: `start_i` while `busy_o`=1 is ignored. The running transfer's access sequence is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a transfer (taken only when idle) |
| op_i | input | 2 | 00 load up, 01 store up, 10 push, 11 pop |
| reg_list_i | input | 8 | Register selection mask |
| base_i | input | 32 | Base address or stack pointer |
| base_idx_i | input | 3 | Index of the base register (ascending load) |
| extra_i | input | 1 | Include link register (push) or program counter (pop) |
| lr_i | input | 32 | Link register value for push |
| mem_valid_o | output | 1 | Memory access request |
| mem_ready_i | input | 1 | Memory accepts/completes the access |
| mem_we_o | output | 1 | 1 write, 0 read |
| mem_addr_o | output | 32 | Word address |
| mem_wdata_o | output | 32 | Write data |
| mem_rdata_i | input | 32 | Read data, valid with ready |
| rf_raddr_o | output | 3 | Register file read index |
| rf_rdata_i | input | 32 | Register file read data |
| rf_we_o | output | 1 | Register file write enable |
| rf_waddr_o | output | 3 | Register file write index |
| rf_wdata_o | output | 32 | Register file write data |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base/stack write-back enable, valid with done |
| wb_value_o | output | 32 | Final base/stack value |
| pc_load_o | output | 1 | Program counter reloaded (branch taken), with done |
| pc_value_o | output | 32 | Reloaded program counter, bit 0 cleared |

## Verification
A corrupted remaining mask shows up at the memory port on the very next access, either as a register index out of order or as a missing or extra access. The bench compares each completed address against the expected list, so it catches this immediately. A wrong address register breaks the 4-byte step at the following access. Its effect on the final pointer shows only in the `done_o` cycle. A stuck extra-word flag shows at completion: the access count is off by one, or `pc_load_o` is wrong.

// File: rtl/bts_pkg.sv
package bts_pkg;
  typedef enum logic [1:0] {
    OP_LD_UP  = 2'b00,
    OP_ST_UP  = 2'b01,
    OP_PUSH   = 2'b10,
    OP_POP    = 2'b11
  } bts_op_e;
endpackage

// File: rtl/bts_bit_pick.sv
module bts_bit_pick #(
  parameter int N         = 8,
  parameter bit LSB_FIRST = 1'b1,
  localparam int IW       = $clog2(N)
) (
  input  logic [N-1:0]  vec_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  assign any_o = |vec_i;

  generate
    if (LSB_FIRST) begin : g_low
      always_comb begin
        idx_o = '0;
        for (int i = N - 1; i >= 0; i--) if (vec_i[i]) idx_o = IW'(i);
      end
    end else begin : g_high
      always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++) if (vec_i[i]) idx_o = IW'(i);
      end
    end
  endgenerate
endmodule

// File: rtl/blk_xfer_seq.sv
module blk_xfer_seq
  import bts_pkg::*;
#(
  parameter int DW   = 32,
  parameter int NREG = 8,
  localparam int IW  = $clog2(NREG),
  localparam int STEP = DW / 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [1:0]      op_i,
  input  logic [NREG-1:0] reg_list_i,
  input  logic [DW-1:0]   base_i,
  input  logic [IW-1:0]   base_idx_i,
  input  logic            extra_i,
  input  logic [DW-1:0]   lr_i,
  output logic            mem_valid_o,
  input  logic            mem_ready_i,
  output logic            mem_we_o,
  output logic [DW-1:0]   mem_addr_o,
  output logic [DW-1:0]   mem_wdata_o,
  input  logic [DW-1:0]   mem_rdata_i,
  output logic [IW-1:0]   rf_raddr_o,
  input  logic [DW-1:0]   rf_rdata_i,
  output logic            rf_we_o,
  output logic [IW-1:0]   rf_waddr_o,
  output logic [DW-1:0]   rf_wdata_o,
  output logic            busy_o,
  output logic            done_o,
  output logic            wb_en_o,
  output logic [DW-1:0]   wb_value_o,
  output logic            pc_load_o,
  output logic [DW-1:0]   pc_value_o
);
  localparam logic [DW-1:0] STEP_V = DW'(STEP);

  logic            busy_q, done_q, wb_en_q, pc_hit_q, extra_q, base_hit_q;
  bts_op_e         op_q;
  logic [NREG-1:0] mask_q;
  logic [DW-1:0]   addr_q, lr_q, pc_q, wb_val_q;

  logic          up_any, dn_any;
  logic [IW-1:0] up_idx, dn_idx, cur_idx;
  logic          down_op, have_item, cur_extra, fire, is_write;

  bts_bit_pick #(.N(NREG), .LSB_FIRST(1'b1)) u_pick_up (
    .vec_i(mask_q), .any_o(up_any), .idx_o(up_idx));
  bts_bit_pick #(.N(NREG), .LSB_FIRST(1'b0)) u_pick_dn (
    .vec_i(mask_q), .any_o(dn_any), .idx_o(dn_idx));

  assign down_op   = (op_q == OP_PUSH);
  assign cur_idx   = down_op ? dn_idx : up_idx;
  // push: extra word goes first; pop: extra word goes after the list
  assign cur_extra = extra_q && (down_op || !up_any);
  assign have_item = up_any || extra_q;
  assign is_write  = (op_q == OP_ST_UP) || (op_q == OP_PUSH);
  assign fire      = busy_q && have_item && mem_ready_i;

  assign mem_valid_o = busy_q && have_item;
  assign mem_we_o    = is_write;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = cur_extra ? lr_q : rf_rdata_i;
  assign rf_raddr_o  = cur_idx;
  assign rf_we_o     = fire && !is_write && !cur_extra;
  assign rf_waddr_o  = cur_idx;
  assign rf_wdata_o  = mem_rdata_i;

  assign busy_o     = busy_q;
  assign done_o     = done_q;
  assign wb_en_o    = done_q && wb_en_q;
  assign wb_value_o = wb_val_q;
  assign pc_load_o  = done_q && pc_hit_q;
  assign pc_value_o = pc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q     <= 1'b0;
      done_q     <= 1'b0;
      wb_en_q    <= 1'b0;
      pc_hit_q   <= 1'b0;
      extra_q    <= 1'b0;
      base_hit_q <= 1'b0;
      op_q       <= OP_LD_UP;
      mask_q     <= '0;
      addr_q     <= '0;
      lr_q       <= '0;
      pc_q       <= '0;
      wb_val_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_i) begin
          busy_q     <= 1'b1;
          op_q       <= bts_op_e'(op_i);
          mask_q     <= reg_list_i;
          addr_q     <= (op_i == OP_PUSH) ? base_i - STEP_V : base_i;
          extra_q    <= extra_i && op_i[1];
          base_hit_q <= reg_list_i[base_idx_i];
          lr_q       <= lr_i;
          pc_hit_q   <= 1'b0;
        end
      end else if (!have_item) begin
        busy_q   <= 1'b0;
        done_q   <= 1'b1;
        wb_en_q  <= !((op_q == OP_LD_UP) && base_hit_q);
        wb_val_q <= down_op ? addr_q + STEP_V : addr_q;
      end else if (fire) begin
        if (cur_extra) begin
          extra_q <= 1'b0;
          if (op_q == OP_POP) begin
            pc_q     <= {mem_rdata_i[DW-1:1], 1'b0};
            pc_hit_q <= 1'b1;
          end
        end else begin
          mask_q[cur_idx] <= 1'b0;
        end
        addr_q <= down_op ? addr_q - STEP_V : addr_q + STEP_V;
      end
    end
  end
endmodule

// File: rtl/blk_xfer_seq_chk.sv
module blk_xfer_seq_chk #(
  parameter int DW = 32,
  parameter int IW = 3
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          mem_valid_o,
  input logic          mem_ready_i,
  input logic          mem_we_o,
  input logic [DW-1:0] mem_addr_o,
  input logic          rf_we_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          pc_load_o,
  input logic [DW-1:0] pc_value_o
);
  a_r11_stall_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && !mem_ready_i |=> mem_valid_o && $stable(mem_addr_o) && $stable(mem_we_o));

  a_r11_valid_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o |-> busy_o);

  a_r2_word_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_valid_o && mem_ready_i |=> !mem_valid_o
      || (mem_addr_o == $past(mem_addr_o) + DW'(4))
      || (mem_addr_o == $past(mem_addr_o) - DW'(4)));

  a_r9_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  a_r9_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o && !mem_valid_o);

  a_r3_rf_write_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rf_we_o |-> mem_valid_o && mem_ready_i && !mem_we_o);

  a_r6_pc_even: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_load_o |-> done_o && !pc_value_o[0]);
endmodule

bind blk_xfer_seq blk_xfer_seq_chk #(.DW(DW), .IW(IW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_valid_o(mem_valid_o), .mem_ready_i(mem_ready_i),
  .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o), .rf_we_o(rf_we_o), .busy_o(busy_o),
  .done_o(done_o), .pc_load_o(pc_load_o), .pc_value_o(pc_value_o));

// File: tb/blk_xfer_seq_tb_top.sv
`timescale 1ns/1ps
module blk_xfer_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [7:0]  list = 8'h00;
  logic [31:0] base = 32'd0;
  logic [2:0]  bidx = 3'd0;
  logic        extra = 1'b0;
  logic [31:0] lr = 32'd0;
  logic        mem_valid, mem_ready, mem_we, rf_we, busy, done, wb_en, pc_load;
  logic [31:0] mem_addr, mem_wdata, mem_rdata, rf_rdata, rf_wdata, wb_value, pc_value;
  logic [2:0]  rf_raddr, rf_waddr;

  logic [31:0] mem [64];
  logic [31:0] regs [8];
  logic [31:0] snap_mem [64];
  logic [31:0] snap_reg [8];
  logic [31:0] log_addr [16];
  logic        log_we [16];
  int          log_n;
  logic        log_clr = 1'b0;
  logic        hold_low = 1'b0;
  logic        rnd_ready = 1'b0;

  int checks = 0;
  int fails = 0;

  logic [31:0] exp_addr [16];
  logic        exp_we [16];
  int          exp_reg [16];
  int          exp_n;
  logic [31:0] exp_wb;
  logic        exp_wb_en;

  always #2 clk = ~clk;

  blk_xfer_seq dut_i (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op), .reg_list_i(list),
    .base_i(base), .base_idx_i(bidx), .extra_i(extra), .lr_i(lr),
    .mem_valid_o(mem_valid), .mem_ready_i(mem_ready), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rf_raddr_o(rf_raddr), .rf_rdata_i(rf_rdata), .rf_we_o(rf_we),
    .rf_waddr_o(rf_waddr), .rf_wdata_o(rf_wdata), .busy_o(busy), .done_o(done),
    .wb_en_o(wb_en), .wb_value_o(wb_value), .pc_load_o(pc_load), .pc_value_o(pc_value));

  assign mem_rdata = mem[mem_addr[7:2]];
  assign rf_rdata  = regs[rf_raddr];

  always @(negedge clk) begin
    if (hold_low) mem_ready <= 1'b0;
    else if (rnd_ready) mem_ready <= ($urandom_range(0, 9) < 7);
    else mem_ready <= 1'b1;
  end

  always @(posedge clk) begin
    if (mem_valid && mem_ready && mem_we) mem[mem_addr[7:2]] <= mem_wdata;
    if (rf_we) regs[rf_waddr] <= rf_wdata;
    if (log_clr) log_n <= 0;
    else if (mem_valid && mem_ready && log_n < 16) begin
      log_addr[log_n] <= mem_addr;
      log_we[log_n]   <= mem_we;
      log_n           <= log_n + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // expected access list, computed from the requirements
  task automatic build_exp(input logic [1:0] o, input logic [7:0] l, input logic [31:0] b,
                           input logic [2:0] bi, input logic x);
    logic [31:0] a;
    exp_n = 0;
    if (o == 2'b10) begin
      a = b - 32'd4;
      if (x) begin
        exp_addr[exp_n] = a; exp_we[exp_n] = 1'b1; exp_reg[exp_n] = 8; exp_n++; a -= 32'd4;
      end
      for (int i = 7; i >= 0; i--) if (l[i]) begin
        exp_addr[exp_n] = a; exp_we[exp_n] = 1'b1; exp_reg[exp_n] = i; exp_n++; a -= 32'd4;
      end
      exp_wb = a + 32'd4;
    end else begin
      a = b;
      for (int i = 0; i < 8; i++) if (l[i]) begin
        exp_addr[exp_n] = a; exp_we[exp_n] = (o == 2'b01); exp_reg[exp_n] = i; exp_n++; a += 32'd4;
      end
      if (o == 2'b11 && x) begin
        exp_addr[exp_n] = a; exp_we[exp_n] = 1'b0; exp_reg[exp_n] = 8; exp_n++; a += 32'd4;
      end
      exp_wb = a;
    end
    exp_wb_en = !(o == 2'b00 && l[bi]);
  endtask

  task automatic launch(input logic [1:0] o, input logic [7:0] l, input logic [31:0] b,
                        input logic [2:0] bi, input logic x, input logic [31:0] lv);
    for (int k = 0; k < 64; k++) snap_mem[k] = mem[k];
    for (int k = 0; k < 8; k++) snap_reg[k] = regs[k];
    build_exp(o, l, b, bi, x);
    @(negedge clk);
    log_clr = 1'b1;
    @(negedge clk);
    log_clr = 1'b0;
    op = o; list = l; base = b; bidx = bi; extra = x; lr = lv; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic finish_check(input string tag, input logic [1:0] o, input logic x, input logic [31:0] lv);
    int wd = 0;
    while (!done && wd < 3000) begin @(negedge clk); wd++; end
    if (!done) begin
      fails++; checks++;
      $display("FAIL %s watchdog actual=%h expected=%h", tag, 0, 1);
      return;
    end
    chk(log_n == exp_n, {tag, " R2 access count"}, log_n, exp_n);
    for (int k = 0; k < exp_n && k < log_n; k++) begin
      chk(log_addr[k] == exp_addr[k], {tag, " R2 R4 address order"}, log_addr[k], exp_addr[k]);
      chk(log_we[k] == exp_we[k], {tag, " R3 direction"}, {31'd0, log_we[k]}, {31'd0, exp_we[k]});
      if (exp_reg[k] == 8) begin
        if (o == 2'b10) chk(mem[exp_addr[k][7:2]] == lv, {tag, " R5 link stored"}, mem[exp_addr[k][7:2]], lv);
        else chk(pc_value == {snap_mem[exp_addr[k][7:2]][31:1], 1'b0}, {tag, " R6 pc value"},
                 pc_value, {snap_mem[exp_addr[k][7:2]][31:1], 1'b0});
      end else if (exp_we[k]) begin
        chk(mem[exp_addr[k][7:2]] == snap_reg[exp_reg[k]], {tag, " R3 store data"},
            mem[exp_addr[k][7:2]], snap_reg[exp_reg[k]]);
      end else begin
        chk(regs[exp_reg[k]] == snap_mem[exp_addr[k][7:2]], {tag, " R3 load data"},
            regs[exp_reg[k]], snap_mem[exp_addr[k][7:2]]);
      end
    end
    chk(wb_en == exp_wb_en, {tag, " R8 writeback enable"}, {31'd0, wb_en}, {31'd0, exp_wb_en});
    chk(wb_value == exp_wb, {tag, " R7 R10 final pointer"}, wb_value, exp_wb);
    chk(pc_load == (o == 2'b11 && x), {tag, " R6 branch taken"}, {31'd0, pc_load}, {31'd0, (o == 2'b11 && x)});
    chk(!busy, {tag, " R9 idle at done"}, {31'd0, busy}, 32'd0);
    @(negedge clk);
    chk(!done, {tag, " R9 done one cycle"}, {31'd0, done}, 32'd0);
  endtask

  task automatic xfer(input string tag, input logic [1:0] o, input logic [7:0] l, input logic [31:0] b,
                      input logic [2:0] bi, input logic x);
    logic [31:0] lv;
    lv = $urandom;
    launch(o, l, b, bi, x, lv);
    finish_check(tag, o, x, lv);
  endtask

  initial begin
    logic [31:0] sb;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 64; k++) mem[k] = $urandom;
    for (int k = 0; k < 8; k++) regs[k] = $urandom;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!busy && !mem_valid && !done && !wb_en && !pc_load && !rf_we, "R1 reset idle",
        {26'd0, busy, mem_valid, done, wb_en, pc_load, rf_we}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !mem_valid, "R1 idle after release", {30'd0, busy, mem_valid}, 32'd0);

    xfer("ldup R2", 2'b00, 8'b1010_0101, 32'd100, 3'd1, 1'b0);
    xfer("ldup base in list R8", 2'b00, 8'b0001_0110, 32'd120, 3'd2, 1'b0);
    xfer("stup R3", 2'b01, 8'h0F, 32'd80, 3'd0, 1'b0);
    xfer("stup base in list R8", 2'b01, 8'h81, 32'd96, 3'd0, 1'b0);
    xfer("push R4", 2'b10, 8'b0110_0011, 32'd160, 3'd0, 1'b0);
    xfer("push lr R5", 2'b10, 8'h90, 32'd140, 3'd0, 1'b1);
    xfer("pop R6", 2'b11, 8'h36, 32'd60, 3'd0, 1'b0);
    xfer("pop pc R6", 2'b11, 8'hC1, 32'd64, 3'd0, 1'b1);
    xfer("full push lr R7", 2'b10, 8'hFF, 32'd180, 3'd0, 1'b1);
    xfer("full pop pc R7", 2'b11, 8'hFF, 32'd144, 3'd0, 1'b1);
    xfer("empty ldup R10", 2'b00, 8'h00, 32'd100, 3'd3, 1'b0);
    xfer("empty stup R10", 2'b01, 8'h00, 32'd104, 3'd3, 1'b0);
    xfer("empty push R10", 2'b10, 8'h00, 32'd108, 3'd0, 1'b0);
    xfer("empty pop R10", 2'b11, 8'h00, 32'd112, 3'd0, 1'b0);
    xfer("empty push lr R5", 2'b10, 8'h00, 32'd116, 3'd0, 1'b1);

    // R11 stall hold and R12 start ignored while busy
    hold_low = 1'b1;
    @(negedge clk);
    launch(2'b01, 8'h03, 32'd72, 3'd0, 1'b0, 32'd0);
    for (int c = 0; c < 5; c++) begin
      chk(mem_valid && mem_addr == 32'd72, "R11 stall holds request", mem_addr, 32'd72);
      if (c == 2) begin
        op = 2'b10; list = 8'hF0; base = 32'd200; start = 1'b1;
      end else start = 1'b0;
      @(negedge clk);
    end
    start = 1'b0;
    chk(log_n == 0, "R11 no access while not ready", log_n, 0);
    hold_low = 1'b0;
    finish_check("stall R12", 2'b01, 1'b0, 32'd0);

    // random mix with random ready
    rnd_ready = 1'b1;
    for (int t = 0; t < 60; t++) begin
      sb = 32'd64 + 32'd4 * $urandom_range(0, 24);
      xfer("random", 2'($urandom_range(0, 3)), 8'($urandom), sb, 3'($urandom_range(0, 7)),
           1'($urandom_range(0, 1)));
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule